// File: doc/BRIEF.md
# Tiny 8-bit Accumulator CPU Core

This block is a small processor that retires one instruction on every clock edge. All of its state is held in flip-flops: a 4-bit program counter, four 8-bit registers, a 4-bit stack pointer, four condition flags (zero, negative, carry, overflow), a sticky halt bit and 16 bytes of memory. Code and data share that memory. Each instruction is 2 or 4 bytes long, and all address arithmetic wraps modulo 16. On each edge the core reads the bytes it needs at the program counter, executes the instruction and updates every piece of state together.

A host loads a program and operands through a side port while `run` is low, then raises `run`. When the core reaches a halt instruction, its state freezes. The host drops `run` and reads the results back from the registers, the memory and the exposed counter, stack and flag values.

Top module: `tcpu8_core`

## Requirements
- R1: After reset, PC is 0, SP is 15, the flags read 0000, halted is low, and every register and memory byte reads 0.
- R2: An instruction starts with the byte at PC, followed by the byte at PC+1. Bits 7:4 of the first byte are the opcode, bits 3:2 name rd and bits 1:0 name rs. Opcodes 0xA to 0xE are 4 bytes long and their address is bits 3:0 of the byte at PC+3. All other opcodes are 2 bytes long. PC and byte addresses wrap modulo 16.
- R3: Opcodes 0x0 to 0x8 write a result to rd, computed from rd (a) and rs (b):
  - 0 ADD: a+b.
  - 1 SUB: a-b.
  - 2 AND, 3 OR, 4 XOR: the bitwise operation.
  - 5 SHL: a shifted left by 1.
  - 6 SHR: a shifted right by 1, logical.
  - 7 MUL: the low byte of a*b.
  - 8 DIV: the unsigned quotient a/b, or 0xFF when b is 0.
- R4: The flags output is {Z,N,C,V}, bits 3 to 0.
  - ADD, SUB, MUL and CMP (0x9) set Z (result is zero) and N (bit 7 of the result).
  - C is the carry out for ADD, and for SUB and CMP it is 1 when a>=b. V is signed overflow. MUL clears both C and V.
  - CMP writes no register.
  - Every other opcode leaves the flags unchanged.
- R5: LOAD (0xA) copies mem[addr] into rd. STORE (0xB) copies rs into mem[addr]. Neither changes the flags.
- R6: JMP (0xC) always loads the address into PC. Jcc (0xD) tests bits 2:0 of the second byte:
  - 0 Z, 1 not Z.
  - 2 C, 3 not C.
  - 4 N, 5 not N.
  - 6 V, 7 not V.
  
  If the condition holds, Jcc loads the address into PC. Otherwise PC advances by 4.
- R7: CALL (0xE) writes 0x00 to mem[SP-1] and PC+4 to mem[SP-2]. It then sets SP to SP-2 and PC to the address. No other instruction changes SP.
- R8: HALT (0xF) sets halted and leaves PC on the halt instruction. From then on, halted stays high and PC, SP, flags, registers and memory no longer change through execution.
- R9: Host writes to registers and memory take effect only while `run` is low, and while `run` is low no instruction executes. Register and memory reads are combinational at any time.
- R10: `retired_o` is high in exactly those cycles in which an instruction commits at the next edge, that is, while `run` is high and the core is not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Execute one instruction per edge while high |
| host_mem_we | input | 1 | Host memory write strobe |
| host_mem_addr | input | 4 | Host memory address, used for both read and write |
| host_mem_wdata | input | 8 | Host memory write data |
| host_mem_rdata | output | 8 | Memory byte at host_mem_addr |
| host_reg_we | input | 1 | Host register write strobe |
| host_reg_sel | input | 2 | Host register index |
| host_reg_wdata | input | 8 | Host register write data |
| host_reg_rdata | output | 8 | Register selected by host_reg_sel |
| pc_o | output | 4 | Program counter |
| sp_o | output | 4 | Stack pointer |
| flags_o | output | 4 | {Z,N,C,V} |
| halted_o | output | 1 | Sticky halt status |
| retired_o | output | 1 | An instruction commits at the coming edge |

## Verification
The bound checker watches the rules of state persistence on every cycle:
- Halt stays set once raised, and while halted the counter, stack and flags do not move.
- Nothing moves while `run` is low.
- SP changes only on a CALL, and always by exactly -2.
- The flags change only on a flag-writing opcode.

The values an instruction produces can be shown only by the bench's programs. These include ALU results and flag values, Jcc decisions for every condition against several flag sets, the CALL push contents, LOAD and STORE data, and fetch wrapping past byte 15.

// File: rtl/tcpu8_pkg.sv
package tcpu8_pkg;
  localparam int DW        = 8;
  localparam int AW        = 4;
  localparam int NREGS     = 4;
  localparam int MEM_BYTES = 1 << AW;
  localparam int RSEL_W    = $clog2(NREGS);

  typedef logic [DW-1:0] byte_t;
  typedef logic [AW-1:0] addr_t;

  typedef enum logic [3:0] {
    OP_ADD = 4'h0, OP_SUB = 4'h1, OP_AND = 4'h2, OP_OR   = 4'h3,
    OP_XOR = 4'h4, OP_SHL = 4'h5, OP_SHR = 4'h6, OP_MUL  = 4'h7,
    OP_DIV = 4'h8, OP_CMP = 4'h9, OP_LD  = 4'hA, OP_ST   = 4'hB,
    OP_JMP = 4'hC, OP_JCC = 4'hD, OP_CALL = 4'hE, OP_HALT = 4'hF
  } opcode_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    byte_t  res;
    flags_t fl;
  } alu_out_t;

  // Arithmetic for opcodes 0x0..0x9; flags are meaningful only for
  // ADD, SUB, MUL and CMP (the caller decides whether to commit them).
  function automatic alu_out_t alu_calc(opcode_e op, byte_t a, byte_t b);
    alu_out_t     r;
    logic [DW:0]  sum;
    logic [DW:0]  dif;
    sum = {1'b0, a} + {1'b0, b};
    dif = {1'b0, a} - {1'b0, b};
    r   = '0;
    r.res = a;
    case (op)
      OP_ADD: begin
        r.res  = sum[DW-1:0];
        r.fl.c = sum[DW];
        r.fl.v = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
      end
      OP_SUB, OP_CMP: begin
        r.res  = dif[DW-1:0];
        r.fl.c = ~dif[DW];
        r.fl.v = (a[DW-1] != b[DW-1]) && (dif[DW-1] != a[DW-1]);
      end
      OP_AND:  r.res = a & b;
      OP_OR:   r.res = a | b;
      OP_XOR:  r.res = a ^ b;
      OP_SHL:  r.res = {a[DW-2:0], 1'b0};
      OP_SHR:  r.res = {1'b0, a[DW-1:1]};
      OP_MUL:  r.res = byte_t'(a * b);
      OP_DIV:  r.res = (b == '0) ? '1 : byte_t'(a / b);
      default: r.res = a;
    endcase
    r.fl.z = (r.res == '0);
    r.fl.n = r.res[DW-1];
    return r;
  endfunction

  // Jcc condition: bits 2:1 pick the flag, bit 0 inverts it.
  function automatic logic cond_true(logic [2:0] cc, flags_t f);
    logic sel;
    case (cc[2:1])
      2'd0:    sel = f.z;
      2'd1:    sel = f.c;
      2'd2:    sel = f.n;
      default: sel = f.v;
    endcase
    return sel ^ cc[0];
  endfunction
endpackage

// File: rtl/tcpu8_fetch.sv
module tcpu8_fetch
  import tcpu8_pkg::*;
(
  input  addr_t             pc_i,
  input  byte_t             mem_i [MEM_BYTES],
  output opcode_e           op_o,
  output logic [RSEL_W-1:0] rd_o,
  output logic [RSEL_W-1:0] rs_o,
  output logic [2:0]        cond_o,
  output addr_t             tgt_o,
  output addr_t             seq_pc_o,
  output logic              reg_wr_o,
  output logic              flag_wr_o,
  output logic              is_call_o,
  output logic              is_halt_o
);
  localparam addr_t OFS1 = addr_t'(1);
  localparam addr_t OFS3 = addr_t'(3);

  byte_t head;
  logic  long_fmt;

  assign head   = mem_i[pc_i];
  assign op_o   = opcode_e'(head[7:4]);
  assign rd_o   = head[3:2];
  assign rs_o   = head[1:0];
  assign cond_o = mem_i[pc_i + OFS1][2:0];
  assign tgt_o  = mem_i[pc_i + OFS3][AW-1:0];

  assign long_fmt  = (op_o == OP_LD) || (op_o == OP_ST) || (op_o == OP_JMP) ||
                     (op_o == OP_JCC) || (op_o == OP_CALL);
  assign seq_pc_o  = pc_i + (long_fmt ? addr_t'(4) : addr_t'(2));
  assign reg_wr_o  = (head[7:4] <= 4'h8) || (op_o == OP_LD);
  assign flag_wr_o = (op_o == OP_ADD) || (op_o == OP_SUB) ||
                     (op_o == OP_MUL) || (op_o == OP_CMP);
  assign is_call_o = (op_o == OP_CALL);
  assign is_halt_o = (op_o == OP_HALT);
endmodule

// File: rtl/tcpu8_alu.sv
module tcpu8_alu
  import tcpu8_pkg::*;
(
  input  opcode_e op_i,
  input  byte_t   a_i,
  input  byte_t   b_i,
  output byte_t   res_o,
  output flags_t  fl_o
);
  alu_out_t r;
  assign r     = alu_calc(op_i, a_i, b_i);
  assign res_o = r.res;
  assign fl_o  = r.fl;
endmodule

// File: rtl/tcpu8_core.sv
module tcpu8_core
  import tcpu8_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        host_mem_we,
  input  logic [3:0]  host_mem_addr,
  input  logic [7:0]  host_mem_wdata,
  output logic [7:0]  host_mem_rdata,
  input  logic        host_reg_we,
  input  logic [1:0]  host_reg_sel,
  input  logic [7:0]  host_reg_wdata,
  output logic [7:0]  host_reg_rdata,
  output logic [3:0]  pc_o,
  output logic [3:0]  sp_o,
  output logic [3:0]  flags_o,
  output logic        halted_o,
  output logic        retired_o
);
  localparam addr_t SP_INIT = addr_t'(MEM_BYTES - 1);

  addr_t  pc_q, sp_q;
  flags_t flags_q;
  logic   halt_q;
  byte_t  regs_q [NREGS];
  byte_t  mem_q  [MEM_BYTES];

  opcode_e           dec_op;
  logic [RSEL_W-1:0] dec_rd, dec_rs;
  logic [2:0]        dec_cond;
  addr_t             dec_tgt, dec_seq_pc;
  logic              dec_reg_wr, dec_flag_wr, dec_is_call, dec_is_halt;

  tcpu8_fetch u_fetch (
    .pc_i      (pc_q),
    .mem_i     (mem_q),
    .op_o      (dec_op),
    .rd_o      (dec_rd),
    .rs_o      (dec_rs),
    .cond_o    (dec_cond),
    .tgt_o     (dec_tgt),
    .seq_pc_o  (dec_seq_pc),
    .reg_wr_o  (dec_reg_wr),
    .flag_wr_o (dec_flag_wr),
    .is_call_o (dec_is_call),
    .is_halt_o (dec_is_halt)
  );

  byte_t  alu_res;
  flags_t alu_fl;

  tcpu8_alu u_alu (
    .op_i  (dec_op),
    .a_i   (regs_q[dec_rd]),
    .b_i   (regs_q[dec_rs]),
    .res_o (alu_res),
    .fl_o  (alu_fl)
  );

  // Named internal events
  logic  exec, host_ok, take, is_store;
  addr_t pc_nxt, sp_m1, sp_m2;
  byte_t wb_data;

  assign exec     = run && !halt_q;
  assign host_ok  = !run;
  assign take     = (dec_op == OP_JMP) || dec_is_call ||
                    ((dec_op == OP_JCC) && cond_true(dec_cond, flags_q));
  assign pc_nxt   = dec_is_halt ? pc_q : (take ? dec_tgt : dec_seq_pc);
  assign wb_data  = (dec_op == OP_LD) ? mem_q[dec_tgt] : alu_res;
  assign is_store = (dec_op == OP_ST);
  assign sp_m1    = sp_q - addr_t'(1);
  assign sp_m2    = sp_q - addr_t'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      sp_q    <= SP_INIT;
      flags_q <= '0;
      halt_q  <= 1'b0;
      for (int i = 0; i < NREGS; i++)     regs_q[i] <= '0;
      for (int j = 0; j < MEM_BYTES; j++) mem_q[j]  <= '0;
    end else begin
      if (host_ok && host_reg_we) regs_q[host_reg_sel] <= host_reg_wdata;
      if (host_ok && host_mem_we) mem_q[host_mem_addr] <= host_mem_wdata;
      if (exec) begin
        pc_q <= pc_nxt;
        if (dec_reg_wr)  regs_q[dec_rd] <= wb_data;
        if (dec_flag_wr) flags_q <= alu_fl;
        if (is_store)    mem_q[dec_tgt] <= regs_q[dec_rs];
        if (dec_is_call) begin
          mem_q[sp_m1] <= '0;
          mem_q[sp_m2] <= byte_t'(dec_seq_pc);
          sp_q         <= sp_m2;
        end
        if (dec_is_halt) halt_q <= 1'b1;
      end
    end
  end

  assign host_mem_rdata = mem_q[host_mem_addr];
  assign host_reg_rdata = regs_q[host_reg_sel];
  assign pc_o           = pc_q;
  assign sp_o           = sp_q;
  assign flags_o        = flags_q;
  assign halted_o       = halt_q;
  assign retired_o      = exec;
endmodule

// File: rtl/tcpu8_core_chk.sv
module tcpu8_core_chk
  import tcpu8_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   run,
  input logic   halted,
  input logic   exec,
  input addr_t  pc,
  input addr_t  sp,
  input flags_t flags,
  input logic   is_call,
  input logic   is_halt,
  input logic   flag_wr
);
  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R8
  halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc) && $stable(sp) && $stable(flags)));

  // R8
  halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && is_halt) |=> halted);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(pc) && $stable(sp) && $stable(flags)));

  // R7
  call_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && is_call) |=> (sp == addr_t'($past(sp) - addr_t'(2))));

  // R7
  sp_only_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec && is_call) |=> $stable(sp));

  // R4
  flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec && flag_wr) |=> $stable(flags));
endmodule

bind tcpu8_core tcpu8_core_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .halted  (halt_q),
  .exec    (exec),
  .pc      (pc_q),
  .sp      (sp_q),
  .flags   (flags_q),
  .is_call (dec_is_call),
  .is_halt (dec_is_halt),
  .flag_wr (dec_flag_wr)
);

// File: tb/tcpu8_core_tb_top.sv
module tcpu8_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       host_mem_we = 1'b0;
  logic [3:0] host_mem_addr = '0;
  logic [7:0] host_mem_wdata = '0;
  logic [7:0] host_mem_rdata;
  logic       host_reg_we = 1'b0;
  logic [1:0] host_reg_sel = '0;
  logic [7:0] host_reg_wdata = '0;
  logic [7:0] host_reg_rdata;
  logic [3:0] pc_o, sp_o, flags_o;
  logic       halted_o, retired_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcpu8_core dut_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .host_mem_we(host_mem_we), .host_mem_addr(host_mem_addr),
    .host_mem_wdata(host_mem_wdata), .host_mem_rdata(host_mem_rdata),
    .host_reg_we(host_reg_we), .host_reg_sel(host_reg_sel),
    .host_reg_wdata(host_reg_wdata), .host_reg_rdata(host_reg_rdata),
    .pc_o(pc_o), .sp_o(sp_o), .flags_o(flags_o),
    .halted_o(halted_o), .retired_o(retired_o)
  );

  // {op[4], a[8], b[8], result[8], flags ZNCV[4]}
  localparam logic [31:0] ALU_VEC [16] = '{
    {4'h0, 8'h05, 8'h03, 8'h08, 4'b0000},
    {4'h0, 8'hFF, 8'h01, 8'h00, 4'b1010},
    {4'h0, 8'h7F, 8'h01, 8'h80, 4'b0101},
    {4'h1, 8'h05, 8'h05, 8'h00, 4'b1010},
    {4'h1, 8'h03, 8'h05, 8'hFE, 4'b0100},
    {4'h1, 8'h80, 8'h01, 8'h7F, 4'b0011},
    {4'h2, 8'hF0, 8'h3C, 8'h30, 4'b0000},
    {4'h3, 8'hF0, 8'h3C, 8'hFC, 4'b0000},
    {4'h4, 8'hF0, 8'h3C, 8'hCC, 4'b0000},
    {4'h5, 8'h81, 8'h00, 8'h02, 4'b0000},
    {4'h6, 8'h81, 8'h00, 8'h40, 4'b0000},
    {4'h7, 8'h10, 8'h11, 8'h10, 4'b0000},
    {4'h7, 8'h10, 8'h10, 8'h00, 4'b1000},
    {4'h8, 8'h64, 8'h07, 8'h0E, 4'b0000},
    {4'h8, 8'h55, 8'h00, 8'hFF, 4'b0000},
    {4'h9, 8'h03, 8'h03, 8'h03, 4'b1010}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    run = 1'b0;
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
  endtask

  task automatic wmem(input logic [3:0] a, input logic [7:0] d);
    host_mem_we = 1'b1; host_mem_addr = a; host_mem_wdata = d;
    tick();
    host_mem_we = 1'b0;
  endtask

  task automatic wreg(input logic [1:0] r, input logic [7:0] d);
    host_reg_we = 1'b1; host_reg_sel = r; host_reg_wdata = d;
    tick();
    host_reg_we = 1'b0;
  endtask

  task automatic rmem(input logic [3:0] a, output logic [7:0] d);
    host_mem_addr = a; #1; d = host_mem_rdata;
  endtask

  task automatic rreg(input logic [1:0] r, output logic [7:0] d);
    host_reg_sel = r; #1; d = host_reg_rdata;
  endtask

  task automatic run_n(input int n);
    run = 1'b1;
    repeat (n) tick();
    run = 1'b0;
  endtask

  function automatic logic jcc_take(input logic [2:0] cc, input logic [3:0] f);
    logic z, n, c, v, s;
    {z, n, c, v} = f;
    case (cc)
      3'd0: s = z;  3'd1: s = !z;
      3'd2: s = c;  3'd3: s = !c;
      3'd4: s = n;  3'd5: s = !n;
      3'd6: s = v;  default: s = !v;
    endcase
    return s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 pc", pc_o, 0);
    chk("R1 sp", sp_o, 15);
    chk("R1 flags", flags_o, 0);
    chk("R1 halted", halted_o, 0);
    rreg(2, d); chk("R1 reg", d, 0);
    rmem(9, d); chk("R1 mem", d, 0);

    // R9 host write/readback while idle
    wreg(3, 8'hA5); rreg(3, d); chk("R9 reg readback", d, 8'hA5);

    // R3 R4 table walk: op R0,R1 at 0; HALT at 2
    for (int i = 0; i < 16; i++) begin
      logic [31:0] v;
      v = ALU_VEC[i];
      do_reset();
      wreg(0, v[27:20]);
      wreg(1, v[19:12]);
      wmem(0, {v[31:28], 4'b0001});
      wmem(2, 8'hF0);
      run_n(2);
      rreg(0, d);
      chk($sformatf("R3 result vec%0d", i), d, v[11:4]);
      chk($sformatf("R4 flags vec%0d", i), flags_o, v[3:0]);
      chk($sformatf("R2 pc vec%0d", i), pc_o, 2);
    end

    // R4 flags preserved by a non-flag op
    do_reset();
    wreg(0, 8'hFF); wreg(1, 8'h01); wreg(2, 8'hF0); wreg(3, 8'h3C);
    wmem(0, 8'h01); wmem(2, 8'h2B); wmem(4, 8'hF0);
    run_n(3);
    rreg(2, d); chk("R3 and into r2", d, 8'h30);
    chk("R4 flags kept after AND", flags_o, 4'b1010);

    // R5 LOAD then STORE
    do_reset();
    wmem(14, 8'h5A); wreg(1, 8'h3C);
    wmem(0, 8'hA8); wmem(3, 8'h0E);
    wmem(4, 8'hB1); wmem(7, 8'h0F);
    wmem(8, 8'hF0);
    run_n(3);
    rreg(2, d); chk("R5 load", d, 8'h5A);
    rmem(15, d); chk("R5 store", d, 8'h3C);
    chk("R5 flags untouched", flags_o, 0);
    chk("R2 pc after 4-byte ops", pc_o, 8);

    // R2 R6 JMP then LOAD straddling the wrap
    do_reset();
    wmem(0, 8'hC0); wmem(3, 8'h0C);
    wmem(12, 8'hAC);
    run = 1'b1; #1;
    chk("R10 retired while running", retired_o, 1);
    tick(); tick();
    run = 1'b0;
    chk("R2 pc wraps to 0", pc_o, 0);
    rreg(3, d); chk("R2 load addr from byte 15", d, 8'hC0);

    // R6 Jcc over 3 flag sets x 8 conditions
    for (int s = 0; s < 3; s++) begin
      logic [7:0] a, b;
      logic [3:0] f;
      case (s)
        0:       begin a = 8'h03; b = 8'h03; f = 4'b1010; end
        1:       begin a = 8'h03; b = 8'h05; f = 4'b0100; end
        default: begin a = 8'h80; b = 8'h01; f = 4'b0011; end
      endcase
      for (int c = 0; c < 8; c++) begin
        do_reset();
        wreg(0, a); wreg(1, b);
        wmem(0, 8'h91); wmem(2, 8'hD0); wmem(3, 8'(c)); wmem(5, 8'h0C);
        run_n(2);
        chk($sformatf("R6 jcc set%0d cond%0d", s, c), pc_o,
            jcc_take(3'(c), f) ? 12 : 6);
      end
    end

    // R7 CALL
    do_reset();
    wmem(14, 8'hFF);
    wmem(0, 8'hE0); wmem(3, 8'h0A); wmem(10, 8'hF0);
    run_n(2);
    chk("R7 pc target", pc_o, 10);
    chk("R7 sp", sp_o, 13);
    rmem(14, d); chk("R7 high push", d, 8'h00);
    rmem(13, d); chk("R7 low push", d, 8'h04);
    chk("R8 halted", halted_o, 1);

    // R8 R9 R10 frozen while halted; host writes ignored while run high
    run = 1'b1;
    host_reg_we = 1'b1; host_reg_sel = 0; host_reg_wdata = 8'h77;
    host_mem_we = 1'b1; host_mem_addr = 0; host_mem_wdata = 8'h11;
    #1;
    chk("R10 no retire when halted", retired_o, 0);
    tick(); tick(); tick();
    run = 1'b0; host_reg_we = 1'b0; host_mem_we = 1'b0;
    chk("R8 pc frozen", pc_o, 10);
    chk("R8 sp frozen", sp_o, 13);
    chk("R8 still halted", halted_o, 1);
    rreg(0, d); chk("R9 reg write ignored", d, 0);
    rmem(0, d); chk("R9 mem write ignored", d, 8'hE0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule